// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Condition Flags

This unit is the shift and rotate slice of an integer execution pipeline. Each operation takes a destination operand, an optional second source operand, a bit count and the incoming carry flag. It produces the new destination value and new carry, zero, sign and overflow flags. Each flag comes with its own update enable, so the flag register outside the unit only changes the flags that the operation actually defines. The operand size is chosen per operation: either the low half-width (16 bits) or the full word (32 bits).

There are nine operations:
- logical shift left and logical shift right;
- arithmetic shift right, which replicates the sign bit;
- plain rotate left and right;
- rotate left and right through the carry, which act as a ring one bit wider than the operand;
- double-precision shift left and right, which feed bits in from the second source operand.

If the effective count is zero, the operation leaves everything untouched: the result equals the destination and no flag update is enabled. A strobe on `in_valid` registers the outcome at the next clock edge. `out_valid` marks the cycle in which the outcome is presented.

Top module: `shift_rotate_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. Result, flags and enables are registered in that same cycle. After reset, all outputs are zero.
- R2: Only `count[4:0]` is used. The effective count is zero in any of these cases: the masked count is 0; a plain rotate count is a multiple of the width; a carry-rotate count is a multiple of width+1; a double shift count is at least the width; or the op code is reserved (9 to 15). In all of these cases the result equals the width-masked destination and all four flag enables are low.
- R3: Op 0 (shift left) fills zeros from the LSB. The carry is the last bit shifted out of the MSB. A count of the width or more gives a zero result. Example: 0xA5A5 shifted left by 1 (16-bit) gives 0x4B4A with carry 1.
- R4: Op 1 (logical right) fills zeros. Op 2 (arithmetic right) fills copies of the original MSB, so counts at or beyond the width give all sign bits. In both, the carry is the last bit shifted out of the LSB. Example: 0xA5A5 arithmetic right by 1 gives 0xD2D2 with carry 1.
- R5: For every active operation, the zero flag is set exactly when the result is zero. The sign flag equals the result MSB, and its enable is high for the shift ops (0, 1, 2, 7, 8) and low for the rotate ops (3 to 6).
- R6: The overflow enable is high only when the effective count is 1. The overflow value depends on the op:
  - ops 0, 7, 3, 5: new carry XOR result MSB;
  - op 1: the original MSB;
  - op 2: 0;
  - op 8: original MSB XOR result MSB;
  - ops 4, 6: XOR of the two top result bits.
- R7: Ops 3 and 4 (rotate left and right) rotate by the count modulo the width. The carry equals the result LSB for a left rotate and the result MSB for a right rotate. Example: 0xA5A5 rotated left by 1 gives 0x4B4B with carry 1 and overflow 1.
- R8: Ops 5 and 6 (rotate through carry, left and right) rotate the ring {carry, operand} by the count modulo width+1. Example: 0xA5A5 with carry 0 rotated left by 1 gives 0x4B4A with carry 1.
- R9: Op 7 shifts the destination left, filling from the MSB end of the source. Op 8 shifts it right, filling from the LSB end of the source. The carry is the last destination bit shifted out. Example: destination 0xA5A5 and source 0x1234, shifted left by 4, give 0x5A51 with carry 0.
- R10: With `wide`=0, the unit works on bits [15:0] only. Input bits [31:16] are ignored and result bits [31:16] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code, 0..8 (9..15 act as no-ops) |
| wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| dst | input | 32 | Destination operand |
| src | input | 32 | Second source operand for the double shifts |
| count | input | 8 | Bit count; only the low 5 bits are used |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Outcome valid pulse |
| result | output | 32 | New destination value |
| cf | output | 1 | Carry flag value |
| cf_we | output | 1 | Carry flag update enable |
| zf | output | 1 | Zero flag value |
| zf_we | output | 1 | Zero flag update enable |
| sf | output | 1 | Sign flag value |
| sf_we | output | 1 | Sign flag update enable |
| of | output | 1 | Overflow flag value |
| of_we | output | 1 | Overflow flag update enable |

## Verification
The assertions assume that every input is sampled only in a cycle with `in_valid` high. They also assume the inputs are at known levels in those cycles, because the zero-count and rotate checks compare the registered outcome against `$past` of the operands. The stimulus drives all inputs at the falling edge, before each strobe, and holds them until the next falling edge, which satisfies both assumptions.

Random op codes cover the reserved range as well. Counts are biased towards 0, 1 and the values around both widths, so that the masking, modulo and saturation corners all occur often.

// File: rtl/sru_pkg.sv
// Shared operation codes for the shift/rotate unit.
// Assumes a 4-bit op field; codes 9..15 are reserved and act as no-ops.
package sru_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SHL  = 4'd0,
        OP_SHR  = 4'd1,
        OP_SAR  = 4'd2,
        OP_ROL  = 4'd3,
        OP_ROR  = 4'd4,
        OP_RCL  = 4'd5,
        OP_RCR  = 4'd6,
        OP_DSHL = 4'd7,
        OP_DSHR = 4'd8
    } sru_op_e;
endpackage

// File: rtl/sru_lane.sv
// One operand-width datapath: turns the raw count into the effective count
// for the op, then forms the result and the carry out by shifting wide
// concatenations. Assumes W <= 32 and a CNT_W-bit count.
module sru_lane
    import sru_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 5
) (
    input  logic [OP_W-1:0]  op,
    input  logic [W-1:0]     dst,
    input  logic [W-1:0]     src,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             eff_zero,
    output logic             eff_one
);
    localparam int EW = CNT_W + 1;

    logic [EW-1:0]  cnt_x, eff;
    logic [2*W:0]   lv, rv;
    logic [2*W-1:0] rl, rr;
    logic [2*W+1:0] cl, cr;
    logic [W-1:0]   lfill, rfill;
    logic [W:0]     ring;

    // Effective count per op: modulo for the rotates, saturation for the
    // arithmetic right shift, zero for out-of-range double shifts.
    always_comb begin
        cnt_x = {1'b0, cnt};
        unique case (op)
            OP_SHL, OP_SHR:   eff = cnt_x;
            OP_SAR:           eff = (cnt_x > EW'(W)) ? EW'(W) : cnt_x;
            OP_ROL, OP_ROR:   eff = cnt_x % EW'(W);
            OP_RCL, OP_RCR:   eff = cnt_x % EW'(W + 1);
            OP_DSHL, OP_DSHR: eff = (cnt_x < EW'(W)) ? cnt_x : '0;
            default:          eff = '0;
        endcase
        eff_zero = (eff == '0);
        eff_one  = (eff == EW'(1));
    end

    // Shifted concatenations for every op family.
    always_comb begin
        lfill = (op == OP_DSHL) ? src : '0;
        if (op == OP_DSHR)     rfill = src;
        else if (op == OP_SAR) rfill = {W{dst[W-1]}};
        else                   rfill = '0;
        ring = {cin, dst};
        lv = {1'b0, dst, lfill} << eff;
        rv = {rfill, dst, 1'b0} >> eff;
        rl = {dst, dst} << eff;
        rr = {dst, dst} >> eff;
        cl = {ring, ring} << eff;
        cr = {ring, ring} >> eff;
    end

    // Pick the result and carry out of the family that the op selects.
    always_comb begin
        res  = dst;
        cout = cin;
        if (!eff_zero) begin
            unique case (op)
                OP_SHL, OP_DSHL: begin res = lv[2*W-1:W]; cout = lv[2*W]; end
                OP_SHR, OP_SAR, OP_DSHR: begin res = rv[W:1]; cout = rv[0]; end
                OP_ROL: begin res = rl[2*W-1:W]; cout = rl[W]; end
                OP_ROR: begin res = rr[W-1:0]; cout = rr[W-1]; end
                OP_RCL: begin res = cl[2*W:W+1]; cout = cl[2*W+1]; end
                OP_RCR: begin res = cr[W-1:0]; cout = cr[W]; end
                default: begin res = dst; cout = cin; end
            endcase
        end
    end
endmodule

// File: rtl/sru_flags.sv
// Flag values and update enables for one operand width.
// Assumes res/cout come from sru_lane for the same op and width.
module sru_flags
    import sru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic            dst_msb,
    input  logic [W-1:0]    res,
    input  logic            cout,
    input  logic            eff_zero,
    input  logic            eff_one,
    output logic [3:0]      val,   // {of, sf, zf, cf}
    output logic [3:0]      we     // {of, sf, zf, cf}
);
    logic is_shift, ovf;

    // Op family and the count-of-one overflow rule.
    always_comb begin
        is_shift = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR)
                || (op == OP_DSHL) || (op == OP_DSHR);
        unique case (op)
            OP_SHL, OP_DSHL, OP_ROL, OP_RCL: ovf = cout ^ res[W-1];
            OP_SHR:          ovf = dst_msb;
            OP_DSHR:         ovf = dst_msb ^ res[W-1];
            OP_ROR, OP_RCR:  ovf = res[W-1] ^ res[W-2];
            default:         ovf = 1'b0;
        endcase
    end

    // Pack values and enables; nothing updates when the count is idle.
    always_comb begin
        val = {ovf, res[W-1], (res == '0), cout};
        we  = {!eff_zero && eff_one, !eff_zero && is_shift, !eff_zero, !eff_zero};
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Shift/rotate execution unit: one lane per operand width, a width mux,
// and an output register stage with a valid pulse. Assumes inputs are
// meaningful only while in_valid is high.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic                wide,
    input  logic [WIDE_W-1:0]   dst,
    input  logic [WIDE_W-1:0]   src,
    input  logic [CNT_IN_W-1:0] count,
    input  logic                carry_in,
    output logic                out_valid,
    output logic [WIDE_W-1:0]   result,
    output logic                cf,
    output logic                cf_we,
    output logic                zf,
    output logic                zf_we,
    output logic                sf,
    output logic                sf_we,
    output logic                of,
    output logic                of_we
);
    localparam int CNT_W = $clog2(WIDE_W);

    logic [1:0][WIDE_W-1:0] lane_res;
    logic [1:0][3:0]        lane_val, lane_we;
    logic [CNT_W-1:0]       cnt_m;

    assign cnt_m = count[CNT_W-1:0];

    // One lane plus flag logic per supported operand width.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
        logic [LW-1:0] r;
        logic co, ez, e1;

        sru_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .op(op), .dst(dst[LW-1:0]), .src(src[LW-1:0]), .cnt(cnt_m),
            .cin(carry_in), .res(r), .cout(co), .eff_zero(ez), .eff_one(e1)
        );
        sru_flags #(.W(LW)) u_flags (
            .op(op), .dst_msb(dst[LW-1]), .res(r), .cout(co),
            .eff_zero(ez), .eff_one(e1), .val(lane_val[g]), .we(lane_we[g])
        );
        assign lane_res[g] = WIDE_W'(r);
    end

    // Output stage: capture the selected lane on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            {of, sf, zf, cf}             <= '0;
            {of_we, sf_we, zf_we, cf_we} <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= lane_res[wide];
                {of, sf, zf, cf}             <= lane_val[wide];
                {of_we, sf_we, zf_we, cf_we} <= lane_we[wide];
            end
        end
    end

    // R1: valid pulse follows the strobe by exactly one cycle.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: a zero masked count leaves the operand and all flags alone.
    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt_m == '0) |=>
        (result == $past(wide ? dst : {{(WIDE_W-NARROW_W){1'b0}}, dst[NARROW_W-1:0]})
         && !cf_we && !zf_we && !sf_we && !of_we));
    // R5: zero flag agrees with the registered result.
    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zf_we) |-> (zf == (result == '0)));
    // R6: overflow is only ever reported together with a carry update.
    a_r6_of_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
        of_we |-> cf_we);
    // R7: a plain rotate keeps the population count of the operand.
    a_r7_rotate_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && (op == OP_ROL || op == OP_ROR)) |=>
        ($countones(result) == $past($countones(dst))));
    // R4: a wide arithmetic right shift keeps the sign.
    a_r4_sar_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && op == OP_SAR && cnt_m != '0) |=> (sf == $past(dst[WIDE_W-1])));
    // R10: narrow operations never touch the upper result bits.
    a_r10_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/shift_rotate_unit_test.sv
module shift_rotate_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        wide = 1'b0;
    logic [31:0] dst = '0, src = '0;
    logic [7:0]  count = '0;
    logic        carry_in = 1'b0;
    logic        out_valid, cf, cf_we, zf, zf_we, sf, sf_we, of, of_we;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    shift_rotate_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
        .dst(dst), .src(src), .count(count), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .cf(cf), .cf_we(cf_we),
        .zf(zf), .zf_we(zf_we), .sf(sf), .sf_we(sf_we), .of(of), .of_we(of_we)
    );

    typedef struct {
        logic [31:0] res;
        logic [3:0]  val;  // {of, sf, zf, cf}
        logic [3:0]  we;
    } exp_t;

    // Bit-serial reference: one single-bit step per effective count.
    function automatic exp_t model(input logic [3:0] o, input logic w32,
                                   input logic [31:0] d0, input logic [31:0] s0,
                                   input logic [7:0] c0, input logic ci);
        exp_t e;
        int w = w32 ? 32 : 16;
        logic [31:0] m = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        logic [31:0] d = d0 & m;
        logic [31:0] s = s0 & m;
        int c = int'(c0 & 8'd31);
        int n;
        logic cy = ci;
        logic b;
        logic omsb = d[w-1];
        logic ov;
        case (o)
            0, 1, 2: n = c;
            3, 4:    n = c % w;
            5, 6:    n = c % (w + 1);
            7, 8:    n = (c < w) ? c : 0;
            default: n = 0;
        endcase
        e.res = d; e.val = '0; e.we = '0;
        if (n == 0) return e;
        for (int i = 0; i < n; i++) begin
            case (o)
                0: begin cy = d[w-1]; d = (d << 1) & m; end
                1: begin cy = d[0]; d = d >> 1; end
                2: begin cy = d[0]; d = (d >> 1) | (32'(omsb) << (w - 1)); end
                3: begin cy = d[w-1]; d = ((d << 1) | 32'(cy)) & m; end
                4: begin cy = d[0]; d = (d >> 1) | (32'(cy) << (w - 1)); end
                5: begin b = d[w-1]; d = ((d << 1) | 32'(cy)) & m; cy = b; end
                6: begin b = d[0]; d = (d >> 1) | (32'(cy) << (w - 1)); cy = b; end
                7: begin cy = d[w-1]; d = ((d << 1) | 32'(s[w-1-i])) & m; end
                default: begin cy = d[0]; d = (d >> 1) | (32'(s[i]) << (w - 1)); end
            endcase
        end
        case (o)
            0, 7, 3, 5: ov = cy ^ d[w-1];
            1:          ov = omsb;
            8:          ov = omsb ^ d[w-1];
            4, 6:       ov = d[w-1] ^ d[w-2];
            default:    ov = 1'b0;
        endcase
        e.res = d;
        e.val = {ov, d[w-1], (d == 0), cy};
        e.we  = {(n == 1), (o <= 2 || o == 7 || o == 8), 1'b1, 1'b1};
        return e;
    endfunction

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            0: return "R3";
            1, 2: return "R4";
            3, 4: return "R7";
            5, 6: return "R8";
            7, 8: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one operation, then compare the registered outcome with the model.
    task automatic run(input logic [3:0] o, input logic w32, input logic [31:0] d,
                       input logic [31:0] s, input logic [7:0] c, input logic ci,
                       input string tag);
        exp_t e;
        @(negedge clk);
        op = o; wide = w32; dst = d; src = s; count = c; carry_in = ci; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e = model(o, w32, d, s, c, ci);
        check("R1", "out_valid", 32'(out_valid), 32'd1);
        check(tag, "result", result, e.res);
        check(tag, "enables", 32'({of_we, sf_we, zf_we, cf_we}), 32'(e.we));
        check("R5 R6", "flags", 32'({of, sf, zf, cf} & e.we), 32'(e.val & e.we));
    endtask

    initial begin
        logic [3:0] o;
        logic [7:0] c;
        int sel;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        check("R1", "reset out_valid", 32'(out_valid), 32'd0);
        check("R1", "reset result", result, 32'd0);
        check("R1", "reset enables", 32'({of_we, sf_we, zf_we, cf_we}), 32'd0);
        rst_n = 1'b1;

        // Directed vectors with known answers.
        run(4'd0, 1'b0, 32'h0000_A5A5, 32'h0, 8'd1, 1'b0, "R3");
        check("R3", "shl 0xA5A5 result", result, 32'h0000_4B4A);
        check("R3", "shl 0xA5A5 carry", 32'(cf), 32'd1);
        run(4'd2, 1'b0, 32'h0000_A5A5, 32'h0, 8'd1, 1'b0, "R4");
        check("R4", "sar 0xA5A5 result", result, 32'h0000_D2D2);
        check("R6", "sar overflow cleared", 32'({of_we, of}), 32'b10);
        run(4'd3, 1'b0, 32'h0000_A5A5, 32'h0, 8'd1, 1'b0, "R7");
        check("R7", "rol 0xA5A5 result", result, 32'h0000_4B4B);
        check("R6", "rol overflow", 32'(of), 32'd1);
        run(4'd5, 1'b0, 32'h0000_A5A5, 32'h0, 8'd1, 1'b0, "R8");
        check("R8", "rcl 0xA5A5 result", result, 32'h0000_4B4A);
        check("R8", "rcl carry", 32'(cf), 32'd1);
        run(4'd7, 1'b0, 32'h0000_A5A5, 32'h0000_1234, 8'd4, 1'b0, "R9");
        check("R9", "dshl result", result, 32'h0000_5A51);
        check("R9", "dshl carry", 32'(cf), 32'd0);
        // Count masking, width-boundary and reserved-op corners.
        run(4'd0, 1'b1, 32'hDEAD_BEEF, 32'h0, 8'd32, 1'b1, "R2");
        check("R2", "count 32 masks to no-op", result, 32'hDEAD_BEEF);
        run(4'd0, 1'b0, 32'h0000_8001, 32'h0, 8'd16, 1'b0, "R3");
        check("R3", "shl by width empties", result, 32'd0);
        run(4'd2, 1'b0, 32'h0000_8000, 32'h0, 8'd20, 1'b0, "R4");
        check("R4", "sar beyond width", result, 32'h0000_FFFF);
        run(4'd3, 1'b0, 32'h0000_1234, 32'h0, 8'd16, 1'b0, "R2");
        run(4'd6, 1'b0, 32'h0000_1234, 32'h0, 8'd17, 1'b1, "R2");
        run(4'd8, 1'b0, 32'h0000_1234, 32'hFFFF, 8'd16, 1'b0, "R2");
        run(4'd11, 1'b1, 32'h1234_5678, 32'h0, 8'd3, 1'b0, "R2");
        run(4'd1, 1'b0, 32'hFFFF_8000, 32'h0, 8'd1, 1'b0, "R10");
        check("R10", "upper input ignored", result, 32'h0000_4000);
        run(4'd6, 1'b1, 32'h0000_0001, 32'h0, 8'd1, 1'b1, "R8");
        run(4'd8, 1'b1, 32'h8000_0000, 32'h0000_0001, 8'd1, 1'b0, "R9");
        @(negedge clk);
        check("R1", "idle out_valid", 32'(out_valid), 32'd0);

        // Random stimulus with counts biased to the corners.
        for (int k = 0; k < 600; k++) begin
            o = 4'($urandom_range(0, 10));
            sel = $urandom_range(0, 5);
            case (sel)
                0: c = 8'd0;
                1: c = 8'd1;
                2: c = 8'($urandom_range(15, 17));
                3: c = 8'($urandom_range(30, 33));
                default: c = 8'($urandom);
            endcase
            run(o, 1'($urandom), $urandom, $urandom, c, 1'($urandom), op_tag(o));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule